// File: doc/BRIEF.md
# Emergency Brake Supervisor

This block is the sequencing core that guards an autonomous vehicle's emergency brake. It starts out holding the vehicle safe. It waits for a start-up self-check to report a result before it lets the vehicle arm. Once the vehicle is armed or running, it watches two things on every clock: a comparator bit that reports the brake's stored energy (tank pressure) is adequate, and the healthy level of the remote emergency stop. A confirmed loss of stored energy, or a stop request, fires the emergency brake and asks for all high-power actuation to be shut down.

After firing, the supervisor does not assume the brake worked. It opens a timed window and waits for a second comparator bit that reports brake-line pressure. If that pressure shows up in time, the braked state is confirmed. If it does not, a redundant braking path is engaged. All three end states hold until an external reset. The pressure thresholds reach the block as ready-made comparator bits, so it handles no analog values.

Top module: `ebrake_sup`

## Requirements
- R1: While `rst_n` is low the block shows state code 0 (initial check), with `shutdown_req`=1, `ebs_trigger`=0 and `redund_act`=0. Reset asserts asynchronously. Release passes through a two-stage synchronizer, so the first clock edge that can change state is the third rising edge after `rst_n` rises.
- R2: In code 0, a sample with `chk_done`=1, `chk_pass`=1, `tank_ok`=1 and `estop_ok`=1 moves the block to code 1 (armed). `go_req` has no effect in code 0.
- R3: In code 0, a sample with `chk_done`=1 and any of `chk_pass`, `tank_ok` or `estop_ok` low moves the block to code 6 (fault).
- R4: In code 1, `go_req`=1 moves the block to code 2 (operating) when no failure is seen on the same sample. A failure on that sample wins and gives code 3.
- R5: In codes 1 and 2, `tank_ok` sampled low on two consecutive clocks moves the block to code 3 (brake triggered) on the second such sample. A single low sample has no effect.
- R6: In codes 1 and 2, one sample of `estop_ok`=0 moves the block to code 3.
- R7: In code 3, if `line_press_ok`=1 is seen on any of the first PRESS_TIMEOUT samples after entry, the block moves to code 4 (brake verified). This includes the last sample of the window.
- R8: If `line_press_ok` stays low for PRESS_TIMEOUT samples in code 3, the block moves to code 5 (redundant active) on the PRESS_TIMEOUT-th sample.
- R9: Codes 4, 5 and 6 are held regardless of any input until reset.
- R10: Outputs follow the state. `shutdown_req`=0 only in codes 1 and 2. `ebs_trigger`=1 in codes 3, 4, 5 and 6. `redund_act`=1 only in code 5. The state code is available one clock after the sample that caused the transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_done | input | 1 | Start-up self-check has produced a result |
| chk_pass | input | 1 | Start-up self-check result is good |
| go_req | input | 1 | Request to move from armed to operating |
| tank_ok | input | 1 | Stored brake energy comparator, 1 = adequate |
| estop_ok | input | 1 | Remote emergency stop healthy, 0 = stop requested |
| line_press_ok | input | 1 | Brake-line pressure comparator, 1 = built up |
| ebs_trigger | output | 1 | Fire the emergency brake |
| redund_act | output | 1 | Engage the redundant braking path |
| shutdown_req | output | 1 | Request removal of high-power actuation |
| state_code | output | 3 | Current state code (0..6) |

## Verification
The stored-energy input is driven with an isolated one-cycle low, which must be filtered, and with a two-cycle low, which must trip. Together these separate the filter from a plain level trigger. The pressure window is driven three ways: pressure arriving early, pressure arriving exactly on the last sample of the window, and no pressure at all. These cases fix the window length to the exact cycle, from both sides. Stop requests are applied both while armed (in the same cycle as a go request) and while operating. The self-check is driven both as passing and as failing with low tank pressure. After each end state is reached, inputs are toggled to show that the end state is held.

// File: rtl/ebrake_sup_pkg.sv
package ebrake_sup_pkg;
  typedef enum logic [2:0] {
    ST_INIT   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_RUN    = 3'd2,
    ST_TRIG   = 3'd3,
    ST_VERIF  = 3'd4,
    ST_REDUND = 3'd5,
    ST_FAULT  = 3'd6
  } sup_state_e;
endpackage

// File: rtl/ebrake_rst_sync.sv
module ebrake_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ebrake_loss_filter.sv
module ebrake_loss_filter #(
  parameter int LOSS_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_ok,
  output logic loss
);
  localparam int HIST = LOSS_SAMPLES - 1;
  logic [HIST-1:0] low_hist_q;

  // history of earlier low samples; loss needs the current one plus HIST before it
  generate
    if (HIST == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_hist_q <= '0;
        else        low_hist_q <= ~level_ok;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_hist_q <= '0;
        else        low_hist_q <= {low_hist_q[HIST-2:0], ~level_ok};
      end
    end
  endgenerate

  assign loss = ~level_ok & (&low_hist_q);
endmodule

// File: rtl/ebrake_press_timer.sv
module ebrake_press_timer #(
  parameter int PRESS_TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(PRESS_TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(PRESS_TIMEOUT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = run | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run & (cnt_q == LAST);
endmodule

// File: rtl/ebrake_sup_fsm.sv
module ebrake_sup_fsm
  import ebrake_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chk_done,
  input  logic       chk_pass,
  input  logic       go_req,
  input  logic       tank_ok,
  input  logic       estop_ok,
  input  logic       tank_loss,
  input  logic       line_press_ok,
  input  logic       win_expired,
  output logic       in_trig,
  output logic       ebs_trigger,
  output logic       redund_act,
  output logic       shutdown_req,
  output logic [2:0] state_code
);
  sup_state_e state_q, state_d;
  logic       trip;
  logic       init_good;

  assign trip      = tank_loss | ~estop_ok;
  assign init_good = chk_pass & tank_ok & estop_ok;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:   if (chk_done) state_d = init_good ? ST_ARMED : ST_FAULT;
      ST_ARMED:  if (trip) state_d = ST_TRIG;
                 else if (go_req) state_d = ST_RUN;
      ST_RUN:    if (trip) state_d = ST_TRIG;
      ST_TRIG:   if (line_press_ok) state_d = ST_VERIF;
                 else if (win_expired) state_d = ST_REDUND;
      ST_VERIF, ST_REDUND, ST_FAULT: state_d = state_q;
      default:   state_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_INIT;
    else        state_q <= state_d;
  end

  always_comb begin
    in_trig      = (state_q == ST_TRIG);
    shutdown_req = !(state_q == ST_ARMED || state_q == ST_RUN);
    ebs_trigger  = (state_q == ST_TRIG) || (state_q == ST_VERIF) ||
                   (state_q == ST_REDUND) || (state_q == ST_FAULT);
    redund_act   = (state_q == ST_REDUND);
    state_code   = state_q;
  end
endmodule

// File: rtl/ebrake_sup.sv
module ebrake_sup #(
  parameter int PRESS_TIMEOUT = 16,
  parameter int LOSS_SAMPLES  = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chk_done,
  input  logic       chk_pass,
  input  logic       go_req,
  input  logic       tank_ok,
  input  logic       estop_ok,
  input  logic       line_press_ok,
  output logic       ebs_trigger,
  output logic       redund_act,
  output logic       shutdown_req,
  output logic [2:0] state_code
);
  logic rst_n_s;
  logic tank_loss;
  logic in_trig;
  logic win_expired;

  ebrake_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  ebrake_loss_filter #(.LOSS_SAMPLES(LOSS_SAMPLES)) u_filt (
    .clk(clk), .rst_n(rst_n_s), .level_ok(tank_ok), .loss(tank_loss)
  );

  ebrake_press_timer #(.PRESS_TIMEOUT(PRESS_TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .run(in_trig), .expired(win_expired)
  );

  ebrake_sup_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s),
    .chk_done(chk_done), .chk_pass(chk_pass), .go_req(go_req),
    .tank_ok(tank_ok), .estop_ok(estop_ok), .tank_loss(tank_loss),
    .line_press_ok(line_press_ok), .win_expired(win_expired),
    .in_trig(in_trig), .ebs_trigger(ebs_trigger), .redund_act(redund_act),
    .shutdown_req(shutdown_req), .state_code(state_code)
  );
endmodule

// File: rtl/ebrake_sup_chk.sv
module ebrake_sup_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       tank_ok,
  input logic       estop_ok,
  input logic       line_press_ok,
  input logic       ebs_trigger,
  input logic       redund_act,
  input logic       shutdown_req,
  input logic [2:0] state_code
);
  a_r2_init_exit: assert property (@(posedge clk) disable iff (!rst_ok)
    state_code == 3'd0 |=> state_code inside {3'd0, 3'd1, 3'd6});

  a_r5_double_low: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_code == 3'd2 && !tank_ok && $past(!tank_ok) && $past(state_code) == 3'd2)
      |=> state_code == 3'd3);

  a_r6_estop: assert property (@(posedge clk) disable iff (!rst_ok)
    (state_code inside {3'd1, 3'd2}) && !estop_ok |=> state_code == 3'd3);

  a_r7_press_seen: assert property (@(posedge clk) disable iff (!rst_ok)
    state_code == 3'd3 && line_press_ok |=> state_code == 3'd4);

  a_r8_redund_entry: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(redund_act) |-> $past(state_code) == 3'd3);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_ok)
    state_code inside {3'd4, 3'd5, 3'd6} |=> $stable(state_code));

  a_r10_trip_stops: assert property (@(posedge clk) disable iff (!rst_ok)
    ebs_trigger |-> shutdown_req);
endmodule

bind ebrake_sup ebrake_sup_chk u_chk (
  .clk(clk), .rst_ok(rst_n_s), .tank_ok(tank_ok), .estop_ok(estop_ok),
  .line_press_ok(line_press_ok), .ebs_trigger(ebs_trigger),
  .redund_act(redund_act), .shutdown_req(shutdown_req), .state_code(state_code)
);

// File: tb/ebrake_sup_tb.sv
module ebrake_sup_tb;
  localparam int CLK_P = 10;
  localparam int T     = 16;

  typedef struct {
    logic [2:0] code;
    string      tag;
  } exp_t;

  logic clk, rst_n;
  logic chk_done, chk_pass, go_req, tank_ok, estop_ok, line_press_ok;
  logic ebs_trigger, redund_act, shutdown_req;
  logic [2:0] state_code;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  exp_t q[$];

  ebrake_sup #(.PRESS_TIMEOUT(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .chk_done(chk_done), .chk_pass(chk_pass),
    .go_req(go_req), .tank_ok(tank_ok), .estop_ok(estop_ok),
    .line_press_ok(line_press_ok), .ebs_trigger(ebs_trigger),
    .redund_act(redund_act), .shutdown_req(shutdown_req), .state_code(state_code)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check_out(input logic [2:0] code, input string tag);
    logic e_sd, e_ebs, e_red;
    e_sd  = !(code == 3'd1 || code == 3'd2);
    e_ebs = (code >= 3'd3);
    e_red = (code == 3'd5);
    checks++;
    if (state_code !== code) begin
      errors++;
      $display("FAIL %s: state_code=%0d expected %0d", tag, state_code, code);
    end
    checks++;
    if ({shutdown_req, ebs_trigger, redund_act} !== {e_sd, e_ebs, e_red}) begin
      errors++;
      $display("FAIL R10 (%s): sd/ebs/red=%b%b%b expected %b%b%b", tag,
               shutdown_req, ebs_trigger, redund_act, e_sd, e_ebs, e_red);
    end
  endtask

  // monitor: one quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check_out(it.code, it.tag);
    end
  end

  task automatic step(input logic cd, cp, go, tk, es, pr,
                      input logic [2:0] code, input string tag);
    exp_t it;
    @(negedge clk);
    chk_done = cd; chk_pass = cp; go_req = go;
    tank_ok = tk; estop_ok = es; line_press_ok = pr;
    it.code = code; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle_inputs();
    chk_done = 0; chk_pass = 0; go_req = 0;
    tank_ok = 1; estop_ok = 1; line_press_ok = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    #1;
    check_out(3'd0, "R1 reset state");
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_out(3'd0, "R1 after sync release");
  endtask

  task automatic to_run();
    step(1,1,0,1,1,0, 3'd1, "R2 checks passed");
    step(0,0,1,1,1,0, 3'd2, "R4 go to operating");
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    // scenario A: filter, early pressure, sticky verified
    do_reset();
    step(0,0,1,1,1,0, 3'd0, "R2 go ignored in init");
    step(1,1,0,1,1,0, 3'd1, "R2 checks passed");
    step(0,0,0,1,1,0, 3'd1, "R4 armed holds");
    step(0,0,1,1,1,0, 3'd2, "R4 go to operating");
    step(0,0,0,0,1,0, 3'd2, "R5 single low ignored");
    step(0,0,0,1,1,0, 3'd2, "R5 recovered");
    step(0,0,0,0,1,0, 3'd2, "R5 first low");
    step(0,0,0,0,1,0, 3'd3, "R5 second low trips");
    step(0,0,0,1,1,0, 3'd3, "R7 waiting");
    step(0,0,0,1,1,1, 3'd4, "R7 early pressure");
    step(0,0,0,1,0,0, 3'd4, "R9 verified sticky");
    step(1,1,1,0,1,0, 3'd4, "R9 verified sticky");
    // scenario B: failed self-check
    do_reset();
    step(1,0,0,1,1,0, 3'd6, "R3 check failed");
    step(1,1,1,1,1,1, 3'd6, "R9 fault sticky");
    step(0,0,0,0,0,0, 3'd6, "R9 fault sticky");
    // scenario C: stop while operating, no pressure
    do_reset();
    to_run();
    step(0,0,0,1,0,0, 3'd3, "R6 stop while operating");
    for (int j = 1; j < T; j++) step(0,0,0,1,1,0, 3'd3, "R8 window open");
    step(0,0,0,1,1,0, 3'd5, "R8 window expired");
    step(0,0,0,1,1,1, 3'd5, "R9 redundant sticky");
    step(1,1,1,1,1,0, 3'd5, "R9 redundant sticky");
    // scenario D: stop while armed with go, pressure on last sample
    do_reset();
    step(1,1,0,1,1,0, 3'd1, "R2 checks passed");
    step(0,0,1,1,0,0, 3'd3, "R4 R6 failure beats go");
    for (int j = 1; j < T; j++) step(0,0,0,1,1,0, 3'd3, "R7 window open");
    step(0,0,0,1,1,1, 3'd4, "R7 pressure on last sample");
    // scenario E: self-check with low tank
    do_reset();
    step(1,1,0,0,1,0, 3'd6, "R3 tank low at check");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule